// File: doc/BRIEF.md
# Glitch-Rejecting Count Input Conditioner

This block sits between an asynchronous external pin and an event counter. It brings the raw pin level into the system clock domain, can optionally screen the level against a slow reference clock of about 2 kHz so that contact bounce and short spikes are discarded, and emits a single-cycle count strobe whenever the conditioned level moves in the selected direction.

With filtering on, a new pin level is taken only once the reference clock has shown two falling edges while the synchronised pin has held that level without a break. Any return to the previously accepted level clears the partial progress. This makes a pulse narrower than one reference period always rejected, and a level held for two full reference periods always accepted. With filtering off, the synchronised pin level goes directly to the edge detector.

The reference input may be a free-running level, synchronised and edge-detected inside the block, or a ready-made one-cycle tick. A parameter picks which.

Top module: `glitch_filter_edge`

## Requirements
- R1: During and just after reset, `level_o` is 1 and `strobe_o` is 0.
- R2: With `filt_en` = 0, a change on `pin_raw` made between clock edges shows on `level_o` right after the third rising clock edge, and not after the second.
- R3: With `filt_en` = 0, every pin pulse of one clock cycle or longer reaches `level_o` and produces its strobe.
- R4: With `filt_en` = 1, a pin pulse shorter than one reference period changes neither `level_o` nor `strobe_o`.
- R5: With `filt_en` = 1, a LOW or HIGH level held for at least two reference periods plus four clock cycles is accepted and produces its strobe.
- R6: With `filt_en` = 1, `level_o` changes only in the cycle right after an internal reference falling-edge event, and only at the second such event seen while the new level is held.
- R7: With `filt_en` = 1, when the synchronised pin returns to the accepted level, the count of reference edges restarts from zero, so chatter made of segments each shorter than one reference period is never accepted.
- R8: `edge_pol` = 0 makes the count event a 1-to-0 change of `level_o`; `edge_pol` = 1 makes it a 0-to-1 change.
- R9: `strobe_o` is high for exactly one clock cycle per matching change of `level_o`, in the same cycle as that change, and never two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Asynchronous external count input |
| ref_tick | input | 1 | Reference clock level (about 2 kHz) or one-cycle tick, per parameter |
| filt_en | input | 1 | 1 enables glitch rejection, 0 bypasses it |
| edge_pol | input | 1 | 0 counts falling edges, 1 counts rising edges |
| level_o | output | 1 | Conditioned pin level |
| strobe_o | output | 1 | One-cycle count strobe |

## Verification
A wrong reference-edge count or a pending change that is not cleared shows as a level change and strobe where none belongs, within two reference periods of the chatter that caused it; a count that never reaches its limit shows as a missing strobe after a long held level. A wrong synchroniser depth shifts the bypass latency by a whole cycle at the next pin change, and a wrong polarity or stretched strobe is visible in the very cycle of the accepted change.

// File: rtl/gfe_pkg.sv
package gfe_pkg;

   typedef enum logic {
      GFE_EDGE_FALL = 1'b0,
      GFE_EDGE_RISE = 1'b1
   } gfe_edge_e;

   // Idle level of the conditioned input after reset.
   localparam logic GFE_IDLE_LEVEL = 1'b1;

   function automatic logic gfe_edge_hit(input logic prev_lvl,
                                         input logic cur_lvl,
                                         input gfe_edge_e sel);
      logic hit;
      hit = 1'b0;
      if (prev_lvl != cur_lvl) begin
         hit = (sel == GFE_EDGE_RISE) ? cur_lvl : ~cur_lvl;
      end
      return hit;
   endfunction

endpackage

// File: rtl/gfe_sync.sv
module gfe_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   initial begin
      if (STAGES < 2) $error("gfe_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= RST_VAL;
               else        chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= RST_VAL;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/gfe_ref_fall.sv
module gfe_ref_fall #(
   parameter bit REF_IS_LEVEL = 1'b1,
   parameter int SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_i,
   output logic fall_o
);

   generate
      if (REF_IS_LEVEL) begin : g_level
         logic ref_sync;
         logic ref_prev_q;

         gfe_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(1'b0)
         ) u_ref_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d_i  (ref_i),
            .q_o  (ref_sync)
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ref_prev_q <= 1'b0;
            else        ref_prev_q <= ref_sync;
         end

         assign fall_o = ref_prev_q & ~ref_sync;
      end else begin : g_tick
         logic tick_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tick_q <= 1'b0;
            else        tick_q <= ref_i;
         end

         assign fall_o = tick_q;
      end
   endgenerate

endmodule

// File: rtl/gfe_accept.sv
module gfe_accept #(
   parameter int ACCEPT_EDGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic lvl_i,
   input  logic ref_fall_i,
   output logic acc_o
);
   import gfe_pkg::*;

   localparam int CNT_W = (ACCEPT_EDGES > 1) ? $clog2(ACCEPT_EDGES) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACCEPT_EDGES - 1);

   initial begin
      if (ACCEPT_EDGES < 1) $error("gfe_accept: ACCEPT_EDGES must be at least 1");
   end

   logic             acc_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= GFE_IDLE_LEVEL;
         cnt_q <= '0;
      end else if (!en_i) begin
         acc_q <= lvl_i;
         cnt_q <= '0;
      end else if (lvl_i == acc_q) begin
         cnt_q <= '0;
      end else if (ref_fall_i) begin
         if (cnt_q == CNT_LAST) begin
            acc_q <= lvl_i;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign acc_o = acc_q;

endmodule

// File: rtl/gfe_edge.sv
module gfe_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   input  logic pol_i,
   output logic strobe_o
);
   import gfe_pkg::*;

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= GFE_IDLE_LEVEL;
      else        prev_q <= lvl_i;
   end

   assign strobe_o = gfe_edge_hit(prev_q, lvl_i, gfe_edge_e'(pol_i));

endmodule

// File: rtl/glitch_filter_edge.sv
module glitch_filter_edge #(
   parameter int SYNC_STAGES  = 2,
   parameter int ACCEPT_EDGES = 2,
   parameter bit REF_IS_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_raw,
   input  logic ref_tick,
   input  logic filt_en,
   input  logic edge_pol,
   output logic level_o,
   output logic strobe_o
);
   import gfe_pkg::*;

   logic pin_sync;
   logic ref_fall_w;
   logic acc_w;

   gfe_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(GFE_IDLE_LEVEL)
   ) u_pin_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (pin_raw),
      .q_o  (pin_sync)
   );

   gfe_ref_fall #(
      .REF_IS_LEVEL(REF_IS_LEVEL),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_ref (
      .clk   (clk),
      .rst_n (rst_n),
      .ref_i (ref_tick),
      .fall_o(ref_fall_w)
   );

   gfe_accept #(
      .ACCEPT_EDGES(ACCEPT_EDGES)
   ) u_accept (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (filt_en),
      .lvl_i     (pin_sync),
      .ref_fall_i(ref_fall_w),
      .acc_o     (acc_w)
   );

   gfe_edge u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_i   (acc_w),
      .pol_i   (edge_pol),
      .strobe_o(strobe_o)
   );

   assign level_o = acc_w;

endmodule

// File: rtl/glitch_filter_edge_chk.sv
module glitch_filter_edge_chk (
   input logic clk,
   input logic rst_n,
   input logic filt_en,
   input logic edge_pol,
   input logic ref_fall,
   input logic level_o,
   input logic strobe_o
);

   // R1: reset state on reset release
   assert_reset_idle_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (level_o && !strobe_o));

   // R6: filtered level moves only after a reference falling-edge event
   assert_change_on_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(filt_en) && (level_o != $past(level_o))) |-> $past(ref_fall));

   // R8: strobe direction follows polarity
   assert_strobe_polarity_R8: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |-> ((level_o == edge_pol) && (level_o != $past(level_o))));

   // R9: strobe never lasts two cycles
   assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |=> !strobe_o);

   // R9: every matching level change yields a strobe
   assert_strobe_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((level_o != $past(level_o)) && (level_o == edge_pol)) |-> strobe_o);

endmodule

bind glitch_filter_edge glitch_filter_edge_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .filt_en (filt_en),
   .edge_pol(edge_pol),
   .ref_fall(ref_fall_w),
   .level_o (level_o),
   .strobe_o(strobe_o)
);

// File: tb/glitch_filter_edge_tb_top.sv
module glitch_filter_edge_tb_top;

   localparam int REF_PERIOD = 32;
   localparam int SETTLE     = 100;

   typedef struct packed {
      logic       en;
      logic       pol;
      logic [7:0] low_w;
      logic [3:0] exp_strobes;
   } vec_t;

   localparam int NVEC = 7;
   localparam vec_t VECS [NVEC] = '{
      '{en: 1'b1, pol: 1'b0, low_w: 8'd12, exp_strobes: 4'd0}, // R4
      '{en: 1'b1, pol: 1'b1, low_w: 8'd12, exp_strobes: 4'd0}, // R4
      '{en: 1'b1, pol: 1'b0, low_w: 8'd80, exp_strobes: 4'd1}, // R5 R8
      '{en: 1'b1, pol: 1'b1, low_w: 8'd80, exp_strobes: 4'd1}, // R5 R8
      '{en: 1'b0, pol: 1'b0, low_w: 8'd3,  exp_strobes: 4'd1}, // R3
      '{en: 1'b0, pol: 1'b1, low_w: 8'd3,  exp_strobes: 4'd1}, // R3
      '{en: 1'b0, pol: 1'b0, low_w: 8'd1,  exp_strobes: 4'd1}  // R3
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pin_raw = 1'b1;
   logic ref_tick = 1'b0;
   logic filt_en = 1'b0;
   logic edge_pol = 1'b0;
   logic level_o;
   logic strobe_o;

   int checks = 0;
   int errors = 0;
   int strobe_cnt = 0;
   logic strobe_prev = 1'b0;
   int ref_cnt = 0;

   always #10 clk = ~clk;

   glitch_filter_edge dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_raw (pin_raw),
      .ref_tick(ref_tick),
      .filt_en (filt_en),
      .edge_pol(edge_pol),
      .level_o (level_o),
      .strobe_o(strobe_o)
   );

   // Reference clock level and strobe monitor, both on the falling edge.
   always @(negedge clk) begin
      ref_cnt  <= (ref_cnt == REF_PERIOD - 1) ? 0 : ref_cnt + 1;
      ref_tick <= (ref_cnt < REF_PERIOD / 2);
      if (rst_n && strobe_o) strobe_cnt <= strobe_cnt + 1;
      if (rst_n && strobe_o && strobe_prev) begin
         errors <= errors + 1;
         $display("FAIL R9 strobe high two cycles: actual 1 expected 0");
      end
      strobe_prev <= strobe_o;
   end

   task automatic check(input string tag, input int act, input int exp_v);
      checks++;
      if (act != exp_v) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp_v);
      end
   endtask

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      wait_neg(3);
      // R1: values held during reset
      check("R1 level in reset", int'(level_o), 1);
      check("R1 strobe in reset", int'(strobe_o), 0);
      rst_n = 1'b1;
      wait_neg(4);
      check("R1 level after reset", int'(level_o), 1);
      check("R1 no strobe after reset", strobe_cnt, 0);

      // Vector table
      for (int v = 0; v < NVEC; v++) begin
         filt_en  = VECS[v].en;
         edge_pol = VECS[v].pol;
         wait_neg(SETTLE);
         strobe_cnt = 0;
         pin_raw = 1'b0;
         wait_neg(int'(VECS[v].low_w));
         pin_raw = 1'b1;
         wait_neg(SETTLE);
         check($sformatf("R3/R4/R5 strobes vec %0d", v), strobe_cnt,
               int'(VECS[v].exp_strobes));
         check($sformatf("R8 final level vec %0d", v), int'(level_o), 1);
      end

      // R2: bypass latency of exactly three edges
      filt_en = 1'b0; edge_pol = 1'b0;
      wait_neg(10);
      pin_raw = 1'b0;
      wait_neg(2);
      check("R2 level after two edges", int'(level_o), 1);
      wait_neg(1);
      check("R2 level after three edges", int'(level_o), 0);
      check("R9 strobe in change cycle", int'(strobe_o), 1);
      wait_neg(1);
      check("R9 strobe gone next cycle", int'(strobe_o), 0);
      pin_raw = 1'b1;
      wait_neg(10);

      // R7: chatter with each low segment under one reference period
      filt_en = 1'b1; edge_pol = 1'b0;
      wait_neg(SETTLE);
      strobe_cnt = 0;
      for (int k = 0; k < 3; k++) begin
         pin_raw = 1'b0; wait_neg(28);
         pin_raw = 1'b1; wait_neg(4);
      end
      wait_neg(SETTLE);
      check("R7 chatter strobes", strobe_cnt, 0);
      check("R7 chatter level", int'(level_o), 1);

      // R5: long low observed as level, held low then released
      strobe_cnt = 0;
      pin_raw = 1'b0;
      wait_neg(2 * REF_PERIOD + 8);
      check("R5 long low accepted", int'(level_o), 0);
      check("R5 one strobe for fall", strobe_cnt, 1);
      pin_raw = 1'b1;
      wait_neg(2 * REF_PERIOD + 8);
      check("R5 long high accepted", int'(level_o), 1);
      check("R8 no strobe on rise with pol 0", strobe_cnt, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule